// File: doc/BRIEF.md
# Gate Driver Fault Supervisor

This block supervises six gate channels of a three-phase bridge driver. Each channel reports three comparator results: drain-source overvoltage, low bootstrap supply (warning level) and supply lockout. A global over-temperature flag is also reported. Every threshold is analog and lies outside this block; only the digital timing and state handling are built here.

A drain-source overvoltage is counted only while its channel is commanded on. A short overvoltage produces a per-channel gate-limit request. A long one forces every channel off and latches a global shutdown. That shutdown holds until the enable input is taken low.

A low bootstrap supply and over-temperature only raise the active-low error flag. A channel in lockout is forced off and its short-circuit counting is masked. After the lockout ends, the channel stays forced off until its command input next changes. A three-bit cause register tells software why the error flag is low.

Top module: `gate_fault_supervisor`

## Requirements
- R1: An overvoltage flag on a channel whose command input is low, or while `en` is low, is never counted: it raises no gate-limit request and no shutdown.
- R2: `gate_lim[i]` rises after `ds_ovr[i]` and `cmd_on[i]` have both been high, with the channel unlocked, for LIM_CYC consecutive rising edges. It falls at the first edge at which that condition is false.
- R3: When the condition of R2 has held for SD_CYC consecutive edges on any channel, `shutdown` goes high and every bit of `force_off` is high from that edge on.
- R4: A shutdown stays latched while `en` is high, even after the overvoltage goes away. The first edge that samples `en` low clears `shutdown` and `fault_cause[0]`.
- R5: Overvoltage episodes shorter than SD_CYC edges, including ones long enough to raise the gate-limit request, never cause a shutdown. The count restarts from zero after every gap.
- R6: A bootstrap warning on any channel sets `fault_cause[1]` and drives `err_n` low one edge later. It forces no channel off.
- R7: `uvlo[i]` high forces `force_off[i]` high from the next edge on. While channel i is locked out, its overvoltage is not counted, so it causes neither a gate limit nor a shutdown. Lockout also sets `fault_cause[1]`.
- R8: After `uvlo[i]` falls, `force_off[i]` stays high. It is released at the first edge at which `cmd_on[i]` differs from its value at the previous edge.
- R9: `ot_warn` sets `fault_cause[2]` and drives `err_n` low one edge later.
- R10: After reset every output is inactive: `err_n` high, `fault_cause` 0, no limit, no forced-off channel, no shutdown. Cause bits ([0] short circuit, [1] supply, [2] temperature) stay latched while `en` is high. While `en` is low, bits [1] and [2] follow their live inputs. `err_n` is low exactly when a cause bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| en | input | 1 | driver enable; low clears a latched shutdown |
| cmd_on | input | NCH | per-channel switch command |
| ds_ovr | input | NCH | per-channel drain-source overvoltage comparator |
| bs_warn | input | NCH | per-channel bootstrap supply warning comparator |
| uvlo | input | NCH | per-channel supply lockout comparator |
| ot_warn | input | 1 | global over-temperature warning |
| gate_lim | output | NCH | per-channel gate-voltage limit request |
| force_off | output | NCH | per-channel forced-off command |
| shutdown | output | 1 | latched global short-circuit shutdown |
| err_n | output | 1 | error flag, active low |
| fault_cause | output | 3 | latched cause: [0] short circuit, [1] supply, [2] temperature |

## Verification
Every result is due a fixed number of edges after its stimulus is first sampled:
- `gate_lim` after LIM_CYC edges and `shutdown` after SD_CYC edges of sustained overvoltage.
- `force_off`, `err_n` and the cause bits after one edge.
- A lockout release at the edge that first sees the command change.

The bench model advances on each rising edge from the same sampled inputs. It is compared with the outputs on the falling edge, so every expected value is read half a cycle after the edge that should produce it. Inputs change one time unit after a rising edge. Directed checks then sample the waveform at the falling edge after the counted number of edges.

// File: rtl/gate_fault_supervisor.sv
module gate_fault_supervisor #(
  parameter int NCH     = 6,
  parameter int LIM_CYC = 10,
  parameter int SD_CYC  = 1100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [NCH-1:0] cmd_on,
  input  logic [NCH-1:0] ds_ovr,
  input  logic [NCH-1:0] bs_warn,
  input  logic [NCH-1:0] uvlo,
  input  logic           ot_warn,
  output logic [NCH-1:0] gate_lim,
  output logic [NCH-1:0] force_off,
  output logic           shutdown,
  output logic           err_n,
  output logic [2:0]     fault_cause
);
  localparam int CW = $clog2(SD_CYC + 1);

  logic [CW-1:0]  cnt [NCH];
  logic [NCH-1:0] lock, cmd_q, mon, sd_hit;
  logic           sd_set, supply_bad;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign mon[g]      = cmd_on[g] & ds_ovr[g] & ~lock[g] & ~uvlo[g] & en & ~shutdown;
    assign sd_hit[g]   = mon[g] && (cnt[g] == CW'(SD_CYC - 1));
    assign gate_lim[g] = cnt[g] >= CW'(LIM_CYC);
  end

  assign sd_set     = |sd_hit;
  assign supply_bad = |bs_warn | |uvlo;
  assign force_off  = lock | {NCH{shutdown}};
  assign err_n      = ~|fault_cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) cnt[i] <= '0;
      lock        <= '0;
      cmd_q       <= '0;
      shutdown    <= 1'b0;
      fault_cause <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (!mon[i])                      cnt[i] <= '0;
        else if (cnt[i] != CW'(SD_CYC))   cnt[i] <= cnt[i] + 1'b1;
        if (uvlo[i])                      lock[i] <= 1'b1;
        else if (cmd_on[i] != cmd_q[i])   lock[i] <= 1'b0;
      end
      cmd_q <= cmd_on;
      if (en) begin
        shutdown    <= shutdown | sd_set;
        fault_cause <= fault_cause | {ot_warn, supply_bad, sd_set};
      end else begin
        shutdown    <= 1'b0;
        fault_cause <= {ot_warn, supply_bad, 1'b0};
      end
    end
  end
endmodule

module gate_fault_supervisor_chk #(
  parameter int NCH = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic [NCH-1:0] cmd_on,
  input logic [NCH-1:0] uvlo,
  input logic           ot_warn,
  input logic [NCH-1:0] gate_lim,
  input logic [NCH-1:0] force_off,
  input logic           shutdown,
  input logic           err_n
);
  p_lim_needs_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_on == '0) |=> (gate_lim == '0));
  p_sd_all_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (&force_off));
  p_sd_latched_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && en) |=> shutdown);
  p_sd_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !shutdown);
  p_lockout_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo != '0) |=> ((force_off & $past(uvlo)) == $past(uvlo)));
  p_ot_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ot_warn |=> !err_n);
endmodule

bind gate_fault_supervisor gate_fault_supervisor_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cmd_on(cmd_on), .uvlo(uvlo),
  .ot_warn(ot_warn), .gate_lim(gate_lim), .force_off(force_off),
  .shutdown(shutdown), .err_n(err_n)
);

// File: tb/gate_fault_supervisor_test.sv
module gate_fault_supervisor_test;
  localparam int CLK_P = 10;
  localparam int NCH = 6, LIM = 10, SD = 1100;

  logic clk = 0, rst_n = 0, en = 0, ot_warn = 0;
  logic [NCH-1:0] cmd_on = '0, ds_ovr = '0, bs_warn = '0, uvlo = '0;
  logic [NCH-1:0] gate_lim, force_off;
  logic shutdown, err_n;
  logic [2:0] fault_cause;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  gate_fault_supervisor #(.NCH(NCH), .LIM_CYC(LIM), .SD_CYC(SD)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .cmd_on(cmd_on), .ds_ovr(ds_ovr),
    .bs_warn(bs_warn), .uvlo(uvlo), .ot_warn(ot_warn), .gate_lim(gate_lim),
    .force_off(force_off), .shutdown(shutdown), .err_n(err_n),
    .fault_cause(fault_cause));

  always #(CLK_P/2) clk = ~clk;

  // reference model
  int run [NCH];
  bit lk [NCH];
  bit pc [NCH];
  bit m_sd;
  bit [2:0] m_cause;

  always @(posedge clk) begin
    bit hit, act, sw;
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin run[i] = 0; lk[i] = 0; pc[i] = 0; end
      m_sd = 0; m_cause = 0;
    end else begin
      hit = 0;
      sw = (bs_warn != 0) || (uvlo != 0);
      for (int i = 0; i < NCH; i++) begin
        act = cmd_on[i] && ds_ovr[i] && !lk[i] && !uvlo[i] && en && !m_sd;
        if (act && run[i] == SD - 1) hit = 1;
        run[i] = act ? ((run[i] < SD) ? run[i] + 1 : SD) : 0;
        if (uvlo[i]) lk[i] = 1;
        else if (cmd_on[i] != pc[i]) lk[i] = 0;
        pc[i] = cmd_on[i];
      end
      if (en) begin
        m_sd = m_sd || hit;
        m_cause = m_cause | {ot_warn, sw, hit};
      end else begin
        m_sd = 0;
        m_cause = {ot_warn, sw, 1'b0};
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [NCH-1:0] el, ef;
    if (!done) begin
      for (int i = 0; i < NCH; i++) begin
        el[i] = run[i] >= LIM;
        ef[i] = lk[i] || m_sd;
      end
      chk("R2 model gate_lim", gate_lim, el);
      chk("R7 model force_off", force_off, ef);
      chk("R3 model shutdown", shutdown, m_sd);
      chk("R10 model fault_cause", fault_cause, m_cause);
      chk("R10 model err_n", err_n, m_cause == 0);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic at_neg;
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    at_neg();
    chk("R10 reset err_n", err_n, 1);
    chk("R10 reset shutdown", shutdown, 0);
    rst_n = 1; en = 1;
    tick(2);

    // R1: overvoltage on a channel that is off
    ds_ovr[0] = 1;
    tick(SD + 20);
    at_neg();
    chk("R1 no limit when off", gate_lim[0], 0);
    chk("R1 no shutdown when off", shutdown, 0);
    ds_ovr[0] = 0;

    // R2/R5: turn-on transients
    cmd_on[1] = 1;
    tick(2);
    for (int k = 0; k < 5; k++) begin
      ds_ovr[1] = 1; tick(4); ds_ovr[1] = 0; tick(3);
    end
    at_neg();
    chk("R5 short burst no limit", gate_lim[1], 0);
    ds_ovr[1] = 1;
    tick(LIM - 1);
    at_neg();
    chk("R2 limit not yet", gate_lim[1], 0);
    tick(1);
    at_neg();
    chk("R2 limit raised", gate_lim[1], 1);
    tick(300);
    ds_ovr[1] = 0;
    tick(1);
    at_neg();
    chk("R2 limit released", gate_lim[1], 0);
    for (int k = 0; k < 4; k++) begin
      ds_ovr[1] = 1; tick(SD - 50); ds_ovr[1] = 0; tick(2);
    end
    at_neg();
    chk("R5 no shutdown on long transients", shutdown, 0);
    cmd_on[1] = 0;

    // R3/R4: sustained short circuit
    cmd_on[2] = 1; ds_ovr[2] = 1;
    tick(SD - 1);
    at_neg();
    chk("R3 shutdown not yet", shutdown, 0);
    tick(1);
    at_neg();
    chk("R3 shutdown", shutdown, 1);
    chk("R3 all forced off", force_off, 6'h3f);
    chk("R3 cause short", fault_cause, 3'b001);
    ds_ovr[2] = 0; cmd_on[2] = 0;
    tick(20);
    at_neg();
    chk("R4 still latched", shutdown, 1);
    en = 0;
    tick(1);
    at_neg();
    chk("R4 cleared", shutdown, 0);
    chk("R4 err released", err_n, 1);
    en = 1;
    tick(2);

    // R6: bootstrap warning
    bs_warn[3] = 1;
    tick(1);
    bs_warn[3] = 0;
    at_neg();
    chk("R6 err low", err_n, 0);
    chk("R6 cause supply", fault_cause, 3'b010);
    chk("R6 nothing forced", force_off, 0);
    en = 0; tick(1); en = 1; tick(1);

    // R7/R8: lockout
    cmd_on[4] = 1; ds_ovr[4] = 1; uvlo[4] = 1;
    tick(1);
    at_neg();
    chk("R7 forced off", force_off[4], 1);
    tick(SD + 20);
    at_neg();
    chk("R7 no shutdown in lockout", shutdown, 0);
    chk("R7 no limit in lockout", gate_lim[4], 0);
    uvlo[4] = 0; ds_ovr[4] = 0;
    tick(5);
    at_neg();
    chk("R8 held after recovery", force_off[4], 1);
    cmd_on[4] = 0;
    tick(1);
    at_neg();
    chk("R8 released on input change", force_off[4], 0);
    en = 0; tick(1); en = 1; tick(1);

    // R9: over-temperature
    ot_warn = 1;
    tick(1);
    ot_warn = 0;
    at_neg();
    chk("R9 err low", err_n, 0);
    chk("R9 cause temperature", fault_cause, 3'b100);
    tick(5);
    at_neg();
    chk("R10 cause held", fault_cause, 3'b100);
    en = 0; tick(1);
    at_neg();
    chk("R10 cleared on disable", err_n, 1);
    tick(2);
    finish_run();
  end
endmodule